// File: doc/BRIEF.md
# Time-Multiplexed Multiport Memory

This block gives surrounding logic the view of a memory with N independent ports: every port has its own read address and read data, and its own write enable, write address and write data. All of the storage sits in one single-port synchronous RAM. The block runs on a fast clock and splits each slow architectural cycle into a fixed schedule of 2N+1 micro-cycles. The first N micro-cycles are reads, one per port. The next one is left free for the user's computation, and the RAM is not touched during it. The last N micro-cycles are writes, one per port.

An architectural cycle begins when the block accepts the cycle-start strobe. At that moment it copies every port input into holding registers. Each port's read result goes into its own output register, and a one-clock valid pulse marks the point where all of them hold the new cycle's data. Reads always come before writes, so a read sees memory as it stood before any write of the same architectural cycle. Writes go out in ascending port order, so when two ports write the same address, the higher-indexed port's data is what remains.

Top module: `tdm_mport_ram`

## Requirements
- R1: A read of an address returns the data last written there in an earlier architectural cycle.
- R2: An accepted `cyc_start` starts a schedule of exactly 2*NPORTS+1 fast clocks. A strobe is accepted when the block is idle or in the final micro-cycle of a schedule, so cycles can run back-to-back with no gap.
- R3: A read in an architectural cycle returns the contents from before any write issued in that same architectural cycle.
- R4: The micro-cycle at index NPORTS is the logic slot. It issues no RAM access and does not change any stored or returned data.
- R5: A port whose write enable is 0 still uses its write slot, but the memory is left unchanged.
- R6: Each port's `rd_data` field holds its value from one schedule to the next. It changes only while the next read phase is being captured.
- R7: `rd_valid` is high for exactly one fast clock, in the clock period after edge NPORTS+1 counted from the edge that accepted the strobe. At that point all NPORTS read fields hold the current cycle's data.
- R8: Writes are issued in ascending port index. When several enabled ports write one address, the data of the highest-indexed port remains.
- R9: Port inputs are captured at the accepted strobe. Later input changes, and strobes that arrive while a schedule runs outside its final micro-cycle, have no effect on that cycle.
- R10: Synchronous active-high reset makes the block idle, clears every `rd_data` field to 0 and forces `rd_valid` low. The next accepted strobe starts with the first read slot.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast micro-cycle clock |
| rst | input | 1 | Synchronous active-high reset |
| cyc_start | input | 1 | Architectural cycle start strobe |
| rd_addr | input | NPORTS*ADDR_W | Read address per port; port p at bits [p*ADDR_W +: ADDR_W] |
| rd_data | output | NPORTS*DATA_W | Registered read data per port; port p at bits [p*DATA_W +: DATA_W] |
| rd_valid | output | 1 | One-clock pulse when all read fields are fresh |
| wr_en | input | NPORTS | Write enable per port; bit p belongs to port p |
| wr_addr | input | NPORTS*ADDR_W | Write address per port |
| wr_data | input | NPORTS*DATA_W | Write data per port |

## Verification
The bench builds the block with NPORTS=4, ADDR_W=6 and DATA_W=16. This gives a 9-micro-cycle schedule and a 64-word array. The bench fills the whole array in a few cycles, and half of the random addresses are drawn from a narrow window. This makes same-address write collisions and read-after-write hits within one architectural cycle frequent. The bench also chains cycles through strobes in the final slot, and sends stray strobes and input changes mid-schedule.

// File: rtl/tdm_mport_pkg.sv
package tdm_mport_pkg;

    typedef enum logic [1:0] {
        SLOT_IDLE  = 2'd0,
        SLOT_READ  = 2'd1,
        SLOT_LOGIC = 2'd2,
        SLOT_WRITE = 2'd3
    } slot_kind_e;

    // number of micro-cycles in one architectural cycle
    function automatic int sched_len(input int nports);
        return 2 * nports + 1;
    endfunction

    // width of an index that selects one of n items (at least 1)
    function automatic int idx_width(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/tdm_sp_ram.sv
module tdm_sp_ram #(
    parameter int ADDR_W = 6,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              en,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] q
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [DEPTH];

    // one access per clock: either a write or a registered read
    always_ff @(posedge clk) begin
        if (en) begin
            if (we) begin
                mem[addr] <= wdata;
            end else begin
                q <= mem[addr];
            end
        end
    end

endmodule

// File: rtl/tdm_seq.sv
module tdm_seq
    import tdm_mport_pkg::*;
#(
    parameter int NPORTS = 4
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic                           cyc_start,
    output logic                           launch,
    output slot_kind_e                     kind,
    output logic [idx_width(NPORTS)-1:0]   port_idx
);
    localparam int SLOTS = sched_len(NPORTS);
    localparam int CW    = idx_width(SLOTS);
    localparam int PW    = idx_width(NPORTS);

    logic          active;
    logic [CW-1:0] cnt;
    logic          last_slot;

    assign last_slot = active && (cnt == CW'(SLOTS - 1));
    assign launch    = cyc_start && (!active || last_slot);

    always_ff @(posedge clk) begin
        if (rst) begin
            active <= 1'b0;
            cnt    <= '0;
        end else if (launch) begin
            active <= 1'b1;
            cnt    <= '0;
        end else if (last_slot) begin
            active <= 1'b0;
            cnt    <= '0;
        end else if (active) begin
            cnt <= cnt + 1'b1;
        end
    end

    // reads, then the logic slot, then writes
    always_comb begin
        kind     = SLOT_IDLE;
        port_idx = '0;
        if (active) begin
            if (cnt < CW'(NPORTS)) begin
                kind     = SLOT_READ;
                port_idx = PW'(cnt);
            end else if (cnt == CW'(NPORTS)) begin
                kind = SLOT_LOGIC;
            end else begin
                kind     = SLOT_WRITE;
                port_idx = PW'(cnt - CW'(NPORTS + 1));
            end
        end
    end

    AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
        active |-> (cnt <= CW'(SLOTS - 1)))
        else $error("slot counter out of range"); // R2

    AST_SLOT_STEP: assert property (@(posedge clk) disable iff (rst)
        (active && !last_slot && !launch) |=> (active && cnt == $past(cnt) + 1'b1))
        else $error("schedule skipped or stalled"); // R2

    AST_MIDRUN_STROBE_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (cyc_start && active && !last_slot) |=> (cnt != '0))
        else $error("strobe restarted a running schedule"); // R9

endmodule

// File: rtl/tdm_port_ctl.sv
module tdm_port_ctl
    import tdm_mport_pkg::*;
#(
    parameter int NPORTS = 4,
    parameter int ADDR_W = 6,
    parameter int DATA_W = 16
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         launch,
    input  slot_kind_e                   kind,
    input  logic [idx_width(NPORTS)-1:0] port_idx,
    input  logic [NPORTS*ADDR_W-1:0]     rd_addr_i,
    input  logic [NPORTS-1:0]            wr_en_i,
    input  logic [NPORTS*ADDR_W-1:0]     wr_addr_i,
    input  logic [NPORTS*DATA_W-1:0]     wr_data_i,
    input  logic [DATA_W-1:0]            ram_q,
    output logic                         ram_en,
    output logic                         ram_we,
    output logic [ADDR_W-1:0]            ram_addr,
    output logic [DATA_W-1:0]            ram_wdata,
    output logic [NPORTS*DATA_W-1:0]     rd_data_o,
    output logic                         rd_valid_o
);
    localparam int PW = idx_width(NPORTS);

    logic [NPORTS*ADDR_W-1:0] h_ra;
    logic [NPORTS-1:0]        h_we;
    logic [NPORTS*ADDR_W-1:0] h_wa;
    logic [NPORTS*DATA_W-1:0] h_wd;

    logic          cap_en;
    logic [PW-1:0] cap_idx;

    // port inputs frozen for the whole schedule
    always_ff @(posedge clk) begin
        if (rst) begin
            h_ra <= '0;
            h_we <= '0;
            h_wa <= '0;
            h_wd <= '0;
        end else if (launch) begin
            h_ra <= rd_addr_i;
            h_we <= wr_en_i;
            h_wa <= wr_addr_i;
            h_wd <= wr_data_i;
        end
    end

    // steer the selected port onto the single RAM path
    always_comb begin
        ram_en    = 1'b0;
        ram_we    = 1'b0;
        ram_addr  = h_ra[int'(port_idx)*ADDR_W +: ADDR_W];
        ram_wdata = h_wd[int'(port_idx)*DATA_W +: DATA_W];
        case (kind)
            SLOT_READ: begin
                ram_en = 1'b1;
            end
            SLOT_WRITE: begin
                ram_addr = h_wa[int'(port_idx)*ADDR_W +: ADDR_W];
                ram_en   = h_we[port_idx];
                ram_we   = h_we[port_idx];
            end
            default: begin
                ram_en = 1'b0;
            end
        endcase
    end

    // RAM output lands one clock after its read slot
    always_ff @(posedge clk) begin
        if (rst) begin
            cap_en     <= 1'b0;
            cap_idx    <= '0;
            rd_valid_o <= 1'b0;
        end else begin
            cap_en     <= (kind == SLOT_READ);
            cap_idx    <= port_idx;
            rd_valid_o <= (kind == SLOT_LOGIC);
        end
    end

    for (genvar p = 0; p < NPORTS; p++) begin : g_rd
        logic [DATA_W-1:0] rd_q;
        always_ff @(posedge clk) begin
            if (rst) begin
                rd_q <= '0;
            end else if (cap_en && cap_idx == PW'(p)) begin
                rd_q <= ram_q;
            end
        end
        assign rd_data_o[p*DATA_W +: DATA_W] = rd_q;
    end

    AST_HOLD_FROZEN: assert property (@(posedge clk) disable iff (rst)
        !launch |=> ($stable(h_ra) && $stable(h_we) && $stable(h_wa) && $stable(h_wd)))
        else $error("holding registers changed mid-schedule"); // R9

    AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (rst)
        !cap_en |=> $stable(rd_data_o))
        else $error("read data moved outside capture"); // R6

    AST_VALID_SINGLE: assert property (@(posedge clk) disable iff (rst)
        rd_valid_o |=> !rd_valid_o)
        else $error("valid longer than one clock"); // R7

    AST_DISABLED_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
        (kind == SLOT_WRITE && !h_we[port_idx]) |-> !ram_we)
        else $error("write issued for disabled port"); // R5

endmodule

// File: rtl/tdm_mport_ram.sv
module tdm_mport_ram
    import tdm_mport_pkg::*;
#(
    parameter int NPORTS = 4,
    parameter int ADDR_W = 6,
    parameter int DATA_W = 16
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     cyc_start,
    input  logic [NPORTS*ADDR_W-1:0] rd_addr,
    output logic [NPORTS*DATA_W-1:0] rd_data,
    output logic                     rd_valid,
    input  logic [NPORTS-1:0]        wr_en,
    input  logic [NPORTS*ADDR_W-1:0] wr_addr,
    input  logic [NPORTS*DATA_W-1:0] wr_data
);
    localparam int PW = idx_width(NPORTS);

    logic              launch;
    slot_kind_e        kind;
    logic [PW-1:0]     port_idx;
    logic              ram_en;
    logic              ram_we;
    logic [ADDR_W-1:0] ram_addr;
    logic [DATA_W-1:0] ram_wdata;
    logic [DATA_W-1:0] ram_q;

    tdm_seq #(
        .NPORTS (NPORTS)
    ) u_seq (
        .clk       (clk),
        .rst       (rst),
        .cyc_start (cyc_start),
        .launch    (launch),
        .kind      (kind),
        .port_idx  (port_idx)
    );

    tdm_port_ctl #(
        .NPORTS (NPORTS),
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_ports (
        .clk        (clk),
        .rst        (rst),
        .launch     (launch),
        .kind       (kind),
        .port_idx   (port_idx),
        .rd_addr_i  (rd_addr),
        .wr_en_i    (wr_en),
        .wr_addr_i  (wr_addr),
        .wr_data_i  (wr_data),
        .ram_q      (ram_q),
        .ram_en     (ram_en),
        .ram_we     (ram_we),
        .ram_addr   (ram_addr),
        .ram_wdata  (ram_wdata),
        .rd_data_o  (rd_data),
        .rd_valid_o (rd_valid)
    );

    tdm_sp_ram #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_ram (
        .clk   (clk),
        .en    (ram_en),
        .we    (ram_we),
        .addr  (ram_addr),
        .wdata (ram_wdata),
        .q     (ram_q)
    );

    AST_LOGIC_SLOT_QUIET: assert property (@(posedge clk) disable iff (rst)
        (kind == SLOT_LOGIC) |-> !ram_en)
        else $error("RAM touched in logic slot"); // R4

    AST_VALID_AFTER_LOGIC: assert property (@(posedge clk) disable iff (rst)
        rd_valid |-> ($past(kind) == SLOT_LOGIC))
        else $error("valid outside its slot"); // R7

    AST_WRITES_AFTER_READS: assert property (@(posedge clk) disable iff (rst)
        ram_we |-> (kind == SLOT_WRITE))
        else $error("write outside write phase"); // R3

endmodule

// File: tb/tdm_mport_ram_tb.sv
`timescale 1ns/1ps
module tdm_mport_ram_tb;
    localparam int NP    = 4;
    localparam int AW    = 6;
    localparam int DW    = 16;
    localparam int DEPTH = 1 << AW;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cyc_start = 1'b0;

    logic [AW-1:0] in_ra [NP];
    logic [AW-1:0] in_wa [NP];
    logic [DW-1:0] in_wd [NP];
    logic          in_we [NP];

    logic [AW-1:0] cur_wa [NP];
    logic [DW-1:0] cur_wd [NP];
    logic          cur_we [NP];

    logic [NP*AW-1:0] rd_addr_f, wr_addr_f;
    logic [NP*DW-1:0] wr_data_f, rd_data;
    logic [NP-1:0]    wr_en_f;
    logic             rd_valid;

    logic [DW-1:0] model [DEPTH];
    logic [DW-1:0] exp_rd [NP];
    logic [DW-1:0] prev_rd [NP];

    int n_tests = 0;
    int n_fail  = 0;

    always #4 clk = ~clk;

    always_comb begin
        for (int i = 0; i < NP; i++) begin
            rd_addr_f[i*AW +: AW] = in_ra[i];
            wr_addr_f[i*AW +: AW] = in_wa[i];
            wr_data_f[i*DW +: DW] = in_wd[i];
            wr_en_f[i]            = in_we[i];
        end
    end

    tdm_mport_ram #(.NPORTS(NP), .ADDR_W(AW), .DATA_W(DW)) u_dut (
        .clk       (clk),
        .rst       (rst),
        .cyc_start (cyc_start),
        .rd_addr   (rd_addr_f),
        .rd_data   (rd_data),
        .rd_valid  (rd_valid),
        .wr_en     (wr_en_f),
        .wr_addr   (wr_addr_f),
        .wr_data   (wr_data_f)
    );

    function automatic logic [DW-1:0] port_rd(input int p);
        return rd_data[p*DW +: DW];
    endfunction

    task automatic check_eq(input string req, input string what,
                            input longint act, input longint exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    endtask

    task automatic rand_inputs();
        for (int i = 0; i < NP; i++) begin
            if ($urandom % 2 == 0) begin
                in_ra[i] = AW'($urandom % 8);
                in_wa[i] = AW'($urandom % 8);
            end else begin
                in_ra[i] = AW'($urandom % DEPTH);
                in_wa[i] = AW'($urandom % DEPTH);
            end
            in_wd[i] = DW'($urandom);
            in_we[i] = ($urandom % 3) != 0;
        end
    endtask

    // one architectural cycle; skip_e0 means the strobe was already accepted
    task automatic do_cycle(input bit skip_e0, input bit noise,
                            input bit chain, input bit chk);
        for (int i = 0; i < NP; i++) begin
            cur_wa[i] = in_wa[i];
            cur_wd[i] = in_wd[i];
            cur_we[i] = in_we[i];
            exp_rd[i] = model[in_ra[i]];
        end
        if (!skip_e0) begin
            @(negedge clk);
            cyc_start = 1'b1;
            @(posedge clk);
            @(negedge clk);
        end
        cyc_start = 1'b0;
        if (noise) begin
            rand_inputs();      // R9: changes after capture must not matter
            cyc_start = 1'b1;   // R9: stray strobe mid-schedule
        end
        for (int k = 1; k <= 2*NP+1; k++) begin
            @(posedge clk);
            @(negedge clk);
            if (k == 1) begin
                cyc_start = 1'b0;
                for (int i = 0; i < NP; i++)
                    check_eq("R6", "read data held before capture", port_rd(i), prev_rd[i]);
            end
            check_eq("R2 R7", $sformatf("rd_valid at micro-cycle %0d", k),
                     rd_valid, (k == NP+1));
            if (k == NP+1) begin
                for (int i = 0; i < NP; i++) begin
                    prev_rd[i] = port_rd(i);
                    if (chk)
                        check_eq("R1 R3 R4 R9", $sformatf("port %0d read data", i),
                                 port_rd(i), exp_rd[i]);
                end
            end
            if (k == 2*NP && chain) begin
                rand_inputs();
                cyc_start = 1'b1;  // R2: accepted in final slot
            end
        end
        for (int i = 0; i < NP; i++)   // R8: ascending order, last writer wins
            if (cur_we[i]) model[cur_wa[i]] = cur_wd[i];
    endtask

    task automatic clear_inputs();
        for (int i = 0; i < NP; i++) begin
            in_ra[i] = '0;
            in_wa[i] = '0;
            in_wd[i] = '0;
            in_we[i] = 1'b0;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        bit sk;
        void'($urandom(32'd20240611));
        clear_inputs();
        for (int i = 0; i < NP; i++) prev_rd[i] = '0;
        for (int a = 0; a < DEPTH; a++) model[a] = '0;

        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R10: reset state
        check_eq("R10", "rd_valid after reset", rd_valid, 0);
        for (int i = 0; i < NP; i++)
            check_eq("R10", $sformatf("port %0d rd_data after reset", i), port_rd(i), 0);

        // fill the whole array
        for (int c = 0; c < DEPTH/NP; c++) begin
            for (int i = 0; i < NP; i++) begin
                in_ra[i] = '0;
                in_wa[i] = AW'(c*NP + i);
                in_wd[i] = DW'($urandom);
                in_we[i] = 1'b1;
            end
            do_cycle(0, 0, 0, 0);
        end

        // R3: read and write of address 5 in the same cycle
        clear_inputs();
        in_ra[0] = AW'(5);
        in_we[1] = 1'b1; in_wa[1] = AW'(5); in_wd[1] = 16'h5A5A;
        do_cycle(0, 0, 0, 1);
        check_eq("R3", "same-cycle read sees old value", port_rd(0), exp_rd[0]);
        clear_inputs();
        for (int i = 0; i < NP; i++) in_ra[i] = AW'(5);
        do_cycle(0, 0, 0, 1);
        check_eq("R1", "next-cycle read sees new value", port_rd(2), 16'h5A5A);

        // R8: every port writes address 9
        clear_inputs();
        for (int i = 0; i < NP; i++) begin
            in_we[i] = 1'b1; in_wa[i] = AW'(9); in_wd[i] = DW'(16'hA000 + i);
        end
        do_cycle(0, 0, 0, 1);
        clear_inputs();
        for (int i = 0; i < NP; i++) in_ra[i] = AW'(9);
        do_cycle(0, 0, 0, 1);
        check_eq("R8", "highest port wins", port_rd(0), 16'hA000 + NP - 1);

        // R5: disabled writes leave address 9 alone
        clear_inputs();
        for (int i = 0; i < NP; i++) begin
            in_we[i] = 1'b0; in_wa[i] = AW'(9); in_wd[i] = 16'hDEAD;
        end
        do_cycle(0, 0, 0, 1);
        clear_inputs();
        in_ra[3] = AW'(9);
        do_cycle(0, 0, 0, 1);
        check_eq("R5", "disabled write ignored", port_rd(3), 16'hA000 + NP - 1);

        // R9: input changes and stray strobe during a schedule
        rand_inputs();
        do_cycle(0, 1, 0, 1);

        // R10: reset in the middle of a schedule (no writes enabled)
        rand_inputs();
        for (int i = 0; i < NP; i++) in_we[i] = 1'b0;
        @(negedge clk);
        cyc_start = 1'b1;
        @(posedge clk);
        @(negedge clk);
        cyc_start = 1'b0;
        repeat (NP + 2) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check_eq("R10", "rd_valid after mid-run reset", rd_valid, 0);
        for (int i = 0; i < NP; i++) begin
            check_eq("R10", $sformatf("port %0d cleared by mid-run reset", i), port_rd(i), 0);
            prev_rd[i] = '0;
        end

        // random mix of isolated and back-to-back cycles
        sk = 1'b0;
        for (int c = 0; c < 300; c++) begin
            bit ch, nz;
            ch = ($urandom % 2) == 0;
            nz = ($urandom % 4) == 0;
            if (!sk) rand_inputs();
            do_cycle(sk, nz, ch, 1);
            sk = ch;
        end
        if (sk) do_cycle(1, 0, 0, 1);

        repeat (4) @(negedge clk);
        check_eq("R2", "idle after last schedule", rd_valid, 0);
        summary();
        $finish;
    end

endmodule